// File: doc/BRIEF.md
# Primary Command Claim Decoder

This block sits on the upstream side of a bus bridge and looks at every address phase. From the 4-bit command code and the 32-bit address, it decides whether the bridge should take the cycle and pass it to the downstream bus.

Three address windows can be programmed: one for I/O, one for memory and one for memory-mapped I/O. Each window is set by an inclusive base/limit pair. I/O commands are checked against the I/O window. Memory commands are checked against both memory windows. Every other command is left for some other agent to take.

The result is registered on the clock edge that follows the frame-start strobe and held until the next strobe. Along with the claim decision, the block gives a compact command-type code that later stages can use.

Top module: `pri_claim_decoder`

## Requirements
- R1: While reset is low and on the first edge after it, `claim` and `forward` are 0 and `cmd_kind` is 0.
- R2: A window hits when base <= address <= limit. Both ends are inclusive and the comparison is unsigned. A window whose base is greater than its limit never hits.
- R3: I/O read (0010) and I/O write (0011) are claimed if and only if the address hits the I/O window.
- R4: Memory read (0110) and memory write (0111) are claimed if and only if the address hits the memory window or the memory-mapped I/O window.
- R5: Interrupt acknowledge (0000) and special cycle (0001) are never claimed, whatever the address is.
- R6: Reserved codes 0100, 0101, 1000 and 1001 are never claimed. Codes 1010 through 1111 are also never claimed.
- R7: Outputs take the decode of the inputs present at a clock edge where `frame_start` is 1. They are visible after that edge and do not change at edges where `frame_start` is 0.
- R8: `forward` always equals `claim`. A claimed cycle is passed downstream, and an unclaimed one is not.
- R9: `cmd_kind` encodes the latched command as follows: 0 for codes 1010–1111, 1 for interrupt acknowledge, 2 for special cycle, 3 for I/O read, 4 for I/O write, 5 for memory read, 6 for memory write, 7 for reserved codes 0100/0101/1000/1001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | High for the clock of an address phase |
| cmd | input | 4 | Command code on the bus |
| addr | input | ADDR_W | Address of the address phase |
| io_base | input | ADDR_W | I/O window lower bound (inclusive) |
| io_limit | input | ADDR_W | I/O window upper bound (inclusive) |
| mem_base | input | ADDR_W | Memory window lower bound |
| mem_limit | input | ADDR_W | Memory window upper bound |
| mmio_base | input | ADDR_W | Memory-mapped I/O window lower bound |
| mmio_limit | input | ADDR_W | Memory-mapped I/O window upper bound |
| claim | output | 1 | Registered: cycle is taken |
| forward | output | 1 | Registered: cycle is passed downstream |
| cmd_kind | output | 3 | Registered decoded command type |

## Verification
The assertions assume that `cmd`, `addr` and the window bounds are stable and known on every edge where `frame_start` is high. They also assume the window bounds do not change between a strobe and the edge after it. The bench meets these assumptions by driving every input on the falling edge and changing the window set only while no strobe is pending. Random addresses are drawn near each window edge, and random codes cover all sixteen values. As a result, each stimulus point is a legal, fully defined address phase.

// File: rtl/pri_claim_decoder.sv
module pri_claim_decoder #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] io_base,
  input  logic [ADDR_W-1:0] io_limit,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic [ADDR_W-1:0] mem_limit,
  input  logic [ADDR_W-1:0] mmio_base,
  input  logic [ADDR_W-1:0] mmio_limit,
  output logic              claim,
  output logic              forward,
  output logic [2:0]        cmd_kind
);

  localparam logic [2:0] K_OTHER = 3'd0;
  localparam logic [2:0] K_IACK  = 3'd1;
  localparam logic [2:0] K_SPEC  = 3'd2;
  localparam logic [2:0] K_IORD  = 3'd3;
  localparam logic [2:0] K_IOWR  = 3'd4;
  localparam logic [2:0] K_MRD   = 3'd5;
  localparam logic [2:0] K_MWR   = 3'd6;
  localparam logic [2:0] K_RSVD  = 3'd7;

  logic io_hit, mem_hit, mmio_hit;
  logic [2:0] kind_d;
  logic claim_d;

  assign io_hit   = (io_base   <= io_limit)   && (addr >= io_base)   && (addr <= io_limit);
  assign mem_hit  = (mem_base  <= mem_limit)  && (addr >= mem_base)  && (addr <= mem_limit);
  assign mmio_hit = (mmio_base <= mmio_limit) && (addr >= mmio_base) && (addr <= mmio_limit);

  always_comb begin
    case (cmd)
      4'b0000: kind_d = K_IACK;
      4'b0001: kind_d = K_SPEC;
      4'b0010: kind_d = K_IORD;
      4'b0011: kind_d = K_IOWR;
      4'b0110: kind_d = K_MRD;
      4'b0111: kind_d = K_MWR;
      4'b0100, 4'b0101, 4'b1000, 4'b1001: kind_d = K_RSVD;
      default: kind_d = K_OTHER;
    endcase
  end

  always_comb begin
    case (kind_d)
      K_IORD, K_IOWR: claim_d = io_hit;
      K_MRD,  K_MWR:  claim_d = mem_hit | mmio_hit;
      default:        claim_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claim    <= 1'b0;
      forward  <= 1'b0;
      cmd_kind <= K_OTHER;
    end else if (frame_start) begin
      claim    <= claim_d;
      forward  <= claim_d;
      cmd_kind <= kind_d;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(claim) && $stable(forward) && $stable(cmd_kind)));

  p_fwd_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    claim == forward);

  p_never_iack_spec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cmd[3:1] == 3'b000) |=> !claim);

  p_never_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && (cmd[3:1] == 3'b010 || cmd[3:1] == 3'b100 || cmd[3] && cmd[2:1] != 2'b00)) |=> !claim);

  p_io_outside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cmd[3:1] == 3'b001 && (addr < io_base || addr > io_limit)) |=> !claim);

  p_mem_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cmd[3:1] == 3'b011 && (addr < mem_base || addr > mem_limit)
      && (addr < mmio_base || addr > mmio_limit)) |=> !claim);

  p_mrd_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cmd == 4'b0110) |=> cmd_kind == 3'd5);

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!claim && !forward && cmd_kind == 3'd0));

endmodule

// File: tb/pri_claim_decoder_test.sv
module pri_claim_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [3:0] cmd = 4'h0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] io_base, io_limit, mem_base, mem_limit, mmio_base, mmio_limit;
  logic claim, forward;
  logic [2:0] cmd_kind;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pri_claim_decoder #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cmd(cmd), .addr(addr),
    .io_base(io_base), .io_limit(io_limit), .mem_base(mem_base), .mem_limit(mem_limit),
    .mmio_base(mmio_base), .mmio_limit(mmio_limit),
    .claim(claim), .forward(forward), .cmd_kind(cmd_kind)
  );

  function automatic bit in_win(input logic [AW-1:0] a, b, l);
    return (b <= l) && (a >= b) && (a <= l);
  endfunction

  function automatic logic [2:0] exp_kind(input logic [3:0] c);
    case (c)
      4'h0: return 3'd1;
      4'h1: return 3'd2;
      4'h2: return 3'd3;
      4'h3: return 3'd4;
      4'h6: return 3'd5;
      4'h7: return 3'd6;
      4'h4, 4'h5, 4'h8, 4'h9: return 3'd7;
      default: return 3'd0;
    endcase
  endfunction

  function automatic bit exp_claim(input logic [3:0] c, input logic [AW-1:0] a);
    if (c == 4'h2 || c == 4'h3) return in_win(a, io_base, io_limit);
    if (c == 4'h6 || c == 4'h7) return in_win(a, mem_base, mem_limit) || in_win(a, mmio_base, mmio_limit);
    return 1'b0;
  endfunction

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'h2, 4'h3: return "R3";
      4'h6, 4'h7: return "R4";
      4'h0, 4'h1: return "R5";
      default:    return "R6";
    endcase
  endfunction

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic phase(input logic [3:0] c, input logic [AW-1:0] a);
    bit ec;
    @(negedge clk);
    cmd = c; addr = a; frame_start = 1'b1;
    ec = exp_claim(c, a);
    @(negedge clk);
    frame_start = 1'b0;
    chk(req_of(c), {7'd0, claim}, {7'd0, ec});
    chk("R8", {7'd0, forward}, {7'd0, ec});
    chk("R9", {5'd0, cmd_kind}, {5'd0, exp_kind(c)});
  endtask

  task automatic hold_check(input logic [3:0] c, input logic [AW-1:0] a);
    logic cl; logic [2:0] k;
    cl = claim; k = cmd_kind;
    @(negedge clk);
    cmd = c; addr = a;
    @(negedge clk);
    chk("R7", {7'd0, claim}, {7'd0, cl});
    chk("R7", {5'd0, cmd_kind}, {5'd0, k});
  endtask

  task automatic edges(input logic [AW-1:0] b, input logic [AW-1:0] l);
    logic [AW-1:0] pts [6];
    pts[0] = b - 1; pts[1] = b; pts[2] = b + 1;
    pts[3] = l - 1; pts[4] = l; pts[5] = l + 1;
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 6; i++) phase(c[3:0], pts[i]);
  endtask

  initial begin
    io_base = 32'h0000_1000; io_limit = 32'h0000_1FFF;
    mem_base = 32'h8000_0000; mem_limit = 32'h8FFF_FFFF;
    mmio_base = 32'hA000_0000; mmio_limit = 32'hA00F_FFFF;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R1", {7'd0, claim}, 8'd0);
    chk("R1", {7'd0, forward}, 8'd0);
    chk("R1", {5'd0, cmd_kind}, 8'd0);
    rst_n = 1'b1;

    // R2 boundary points for every code on each window
    edges(io_base, io_limit);
    edges(mem_base, mem_limit);
    edges(mmio_base, mmio_limit);

    // R7 hold with no strobe
    phase(4'h2, 32'h0000_1800);
    hold_check(4'h1, 32'h0000_0000);
    phase(4'h0, 32'h8000_0000);
    hold_check(4'h7, 32'h8000_0010);

    // R2 disabled window: base > limit
    @(negedge clk);
    io_base = 32'h0000_2000; io_limit = 32'h0000_1000;
    phase(4'h2, 32'h0000_1800);
    phase(4'h3, 32'h0000_2000);
    phase(4'h3, 32'h0000_1000);
    @(negedge clk);
    io_base = 32'h0000_1000; io_limit = 32'h0000_1FFF;

    // random mix near edges
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      logic [AW-1:0] anchors [6];
      anchors[0] = io_base; anchors[1] = io_limit; anchors[2] = mem_base;
      anchors[3] = mem_limit; anchors[4] = mmio_base; anchors[5] = mmio_limit;
      if ($urandom_range(3) == 0) a = $urandom;
      else a = anchors[$urandom_range(5)] + AW'($urandom_range(8)) - AW'(4);
      phase(4'($urandom_range(15)), a);
      if ($urandom_range(15) == 0) hold_check(4'($urandom_range(15)), $urandom);
    end

    // R1 reset mid-run
    phase(4'h6, 32'h8000_0004);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1", {7'd0, claim}, 8'd0);
    chk("R1", {5'd0, cmd_kind}, 8'd0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule